// File: doc/BRIEF.md
# Capture, Compare and PWM Unit

This block turns a free-running 16-bit timer and a period counter, both supplied from outside, into one of three timing functions. A 4-bit mode field picks the function. In capture modes the unit records the timer value when the input pin shows a chosen edge, optionally after counting several rising edges. In compare modes it watches for the timer to equal a 16-bit compare value and then sets or clears the output pin, raises only an interrupt, or fires a special event that clears the timer and starts a conversion. In PWM modes it drives a pulse-width-modulated output with a 10-bit duty value.

The mode sits in the low four bits of a 6-bit control input. The two bits above the mode are the two least significant bits of the PWM duty value. The eight upper duty bits arrive on a separate input. The PWM period counter is 10 bits wide, and a separate pulse marks the first cycle of each period. Reset is asynchronous and active low, and its release is synchronised inside the block. Outputs therefore respond to other inputs only from the third rising edge after reset is released.

Top module: `ccp_unit`

## Requirements
- R1: While reset is held, and after it is released, `pin_o`, `irq_o`, `tmr_clr_o` and `adc_go_o` are 0 and `cap_val_o` is 0.
- R2: Mode codes 0000 through 0011 turn the unit off. Pin edges and compare matches then raise no interrupt, `cap_val_o` keeps its value, and `pin_o` is 0.
- R3: In mode 0100, a 1-to-0 change of `cap_pin_i` copies the `timer_i` value of that cycle into `cap_val_o`, and `irq_o` pulses for one cycle on the next rising edge. A 0-to-1 change has no effect.
- R4: In mode 0101, a 0-to-1 change of `cap_pin_i` captures as in R3, and a 1-to-0 change has no effect.
- R5: Mode 0110 captures on every 4th rising edge of `cap_pin_i` and mode 0111 on every 16th. Edges in between raise no interrupt.
- R6: Any change of the mode field clears the rising-edge count, so that after a change a prescaled mode again needs its full number of edges.
- R7: Entering mode 1000 drives `pin_o` to 0, and entering mode 1001 drives it to 1. On a match, 1000 drives `pin_o` to 1 and 1001 drives it to 0.
- R8: A match is the cycle in which `timer_i == cmp_val_i` becomes true. In every mode from 1000 to 1011, a match pulses `irq_o` once even if the equality then persists. In modes 1010 and 1011, `pin_o` stays 0.
- R9: In mode 1011, a match also gives a one-cycle pulse on both `tmr_clr_o` and `adc_go_o`.
- R10: Any mode 11xx is PWM with duty D = {`duty_hi_i`, `ctrl_i[5:4]`}. `pin_o` rises after a cycle with `pwm_start_i`=1 (count 0), and falls after the cycle whose count equals D. It is therefore high for min(D, period) cycles per period, and stays low when D is 0.
- R11: The duty value is taken only in the period-start cycle. A duty change in the middle of a period takes effect in the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 6 | [3:0] mode, [5:4] duty LSBs |
| timer_i | input | 16 | Free-running timer value |
| cmp_val_i | input | 16 | Compare value |
| cap_pin_i | input | 1 | Capture input pin (synchronous) |
| duty_hi_i | input | 8 | Upper eight duty bits |
| pwm_cnt_i | input | 10 | PWM period count |
| pwm_start_i | input | 1 | First cycle of a PWM period |
| cap_val_o | output | 16 | Last captured timer value |
| pin_o | output | 1 | Compare or PWM output pin |
| irq_o | output | 1 | Capture or match interrupt pulse |
| tmr_clr_o | output | 1 | Special-event timer clear pulse |
| adc_go_o | output | 1 | Special-event conversion start pulse |

## Verification
The PWM vectors cover duty 0, duty 1, duty equal to the period and duty above it. A design that mis-handles the comparison boundary gives one cycle too many or too few of high output, or a glitch when the duty is 0. Prescaled capture is tested by counting the interrupts across a run of edges and by changing the mode partway through a count. A design that does not clear the count on a mode change captures early. A timer that stays equal to the compare value must raise one interrupt and no more. A mid-period duty change must not shorten the period already running. The tests also cover the set and clear presets made on entering a compare mode and the silence of the off codes.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  typedef enum logic [1:0] {K_OFF, K_CAP, K_CMP, K_PWM} kind_e;

  localparam logic [3:0] M_CAP_FALL = 4'b0100;
  localparam logic [3:0] M_CAP_RISE = 4'b0101;
  localparam logic [3:0] M_CAP_4    = 4'b0110;
  localparam logic [3:0] M_CAP_16   = 4'b0111;
  localparam logic [3:0] M_CMP_SET  = 4'b1000;
  localparam logic [3:0] M_CMP_CLR  = 4'b1001;
  localparam logic [3:0] M_CMP_IRQ  = 4'b1010;
  localparam logic [3:0] M_CMP_TRIG = 4'b1011;

  function automatic kind_e mode_kind(input logic [3:0] m);
    casez (m)
      4'b11??: mode_kind = K_PWM;
      4'b10??: mode_kind = K_CMP;
      4'b01??: mode_kind = K_CAP;
      default: mode_kind = K_OFF;
    endcase
  endfunction
endpackage

// File: rtl/ccp_capture.sv
module ccp_capture import ccp_pkg::*; #(
  parameter int TMR_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode_i,
  input  logic             mode_chg_i,
  input  logic             pin_i,
  input  logic [TMR_W-1:0] timer_i,
  output logic [TMR_W-1:0] cap_o,
  output logic             irq_o
);
  localparam logic [PRE_W-1:0] LAST_4  = PRE_W'(3);
  localparam logic [PRE_W-1:0] LAST_16 = PRE_W'(15);

  logic             prev_q, irq_q, irq_n;
  logic [PRE_W-1:0] cnt_q, cnt_n;
  logic [TMR_W-1:0] cap_q, cap_n;
  logic             rise, fall, ev;
  logic [PRE_W-1:0] last;

  assign rise = pin_i & ~prev_q;
  assign fall = ~pin_i & prev_q;
  assign last = (mode_i == M_CAP_4) ? LAST_4 : LAST_16;

  always_comb begin
    ev    = 1'b0;
    cnt_n = cnt_q;
    unique case (mode_i)
      M_CAP_FALL: ev = fall;
      M_CAP_RISE: ev = rise;
      M_CAP_4, M_CAP_16: begin
        if (!mode_chg_i && rise) begin
          if (cnt_q == last) begin
            ev    = 1'b1;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: ev = 1'b0;
    endcase
    if (mode_chg_i) cnt_n = '0;
    cap_n = ev ? timer_i : cap_q;
    irq_n = ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      cap_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      cnt_q  <= cnt_n;
      cap_q  <= cap_n;
      irq_q  <= irq_n;
    end
  end

  assign cap_o = cap_q;
  assign irq_o = irq_q;

  AST_CAP_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_q) |-> irq_q); // R3
  AST_CAP_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R4
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare import ccp_pkg::*; #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode_i,
  input  logic             mode_chg_i,
  input  logic [TMR_W-1:0] timer_i,
  input  logic [TMR_W-1:0] cmp_i,
  output logic             pin_o,
  output logic             irq_o,
  output logic             go_o
);
  logic eq, eq_q, hit;
  logic pin_q, pin_n, irq_q, go_q, go_n;

  assign eq  = (timer_i == cmp_i);
  assign hit = eq & ~eq_q & (mode_kind(mode_i) == K_CMP);

  always_comb begin
    pin_n = pin_q;
    if (mode_chg_i) begin
      if (mode_i == M_CMP_SET) pin_n = 1'b0;
      if (mode_i == M_CMP_CLR) pin_n = 1'b1;
    end
    if (hit) begin
      if (mode_i == M_CMP_SET) pin_n = 1'b1;
      if (mode_i == M_CMP_CLR) pin_n = 1'b0;
    end
    go_n = hit & (mode_i == M_CMP_TRIG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q  <= 1'b0;
      pin_q <= 1'b0;
      irq_q <= 1'b0;
      go_q  <= 1'b0;
    end else begin
      eq_q  <= eq;
      pin_q <= pin_n;
      irq_q <= hit;
      go_q  <= go_n;
    end
  end

  assign pin_o = pin_q;
  assign irq_o = irq_q;
  assign go_o  = go_q;

  AST_CMP_PIN_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_q) |-> ($past(mode_i) == M_CMP_SET || $past(mode_i) == M_CMP_CLR)); // R7
  AST_CMP_IRQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R8
  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> (irq_q && $past(mode_i) == M_CMP_TRIG)); // R9
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DUTY_W-1:0] cnt_i,
  input  logic              start_i,
  output logic              out_o
);
  logic [DUTY_W-1:0] duty_q, duty_n;
  logic              out_q, out_n;
  logic              duty_en;

  assign duty_en = en_i & start_i;

  always_comb begin
    duty_n = duty_en ? duty_i : duty_q;
    out_n  = out_q;
    if (!en_i)                out_n = 1'b0;
    else if (start_i)         out_n = (duty_i != '0);
    else if (cnt_i == duty_q) out_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      out_q  <= 1'b0;
    end else begin
      duty_q <= duty_n;
      out_q  <= out_n;
    end
  end

  assign out_o = out_q;

  AST_PWM_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(start_i)); // R10
  AST_PWM_DUTY_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start_i) |-> $stable(duty_q)); // R11
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit import ccp_pkg::*; #(
  parameter int TMR_W     = 16,
  parameter int DUTY_HI_W = 8,
  parameter int DUTY_LO_W = 2,
  parameter int PRE_W     = 4,
  localparam int DUTY_W   = DUTY_HI_W + DUTY_LO_W,
  localparam int CTRL_W   = 4 + DUTY_LO_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CTRL_W-1:0]    ctrl_i,
  input  logic [TMR_W-1:0]     timer_i,
  input  logic [TMR_W-1:0]     cmp_val_i,
  input  logic                 cap_pin_i,
  input  logic [DUTY_HI_W-1:0] duty_hi_i,
  input  logic [DUTY_W-1:0]    pwm_cnt_i,
  input  logic                 pwm_start_i,
  output logic [TMR_W-1:0]     cap_val_o,
  output logic                 pin_o,
  output logic                 irq_o,
  output logic                 tmr_clr_o,
  output logic                 adc_go_o
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic [3:0]  mode, mode_q;
  logic        mode_chg;
  kind_e       kind;
  logic        cap_irq, cmp_irq, cmp_pin, pwm_out, go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode     = ctrl_i[3:0];
  assign kind     = mode_kind(mode);
  assign mode_chg = (mode != mode_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= '0;
    else            mode_q <= mode;
  end

  ccp_capture #(.TMR_W(TMR_W), .PRE_W(PRE_W)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .mode_i(mode), .mode_chg_i(mode_chg),
    .pin_i(cap_pin_i), .timer_i(timer_i), .cap_o(cap_val_o), .irq_o(cap_irq));

  ccp_compare #(.TMR_W(TMR_W)) u_cmp (
    .clk(clk), .rst_n(rst_int_n), .mode_i(mode), .mode_chg_i(mode_chg),
    .timer_i(timer_i), .cmp_i(cmp_val_i), .pin_o(cmp_pin), .irq_o(cmp_irq),
    .go_o(go));

  ccp_pwm #(.DUTY_W(DUTY_W)) u_pwm (
    .clk(clk), .rst_n(rst_int_n), .en_i(kind == K_PWM),
    .duty_i({duty_hi_i, ctrl_i[CTRL_W-1:4]}), .cnt_i(pwm_cnt_i),
    .start_i(pwm_start_i), .out_o(pwm_out));

  always_comb begin
    unique case (kind)
      K_PWM:   pin_o = pwm_out;
      K_CMP:   pin_o = (mode == M_CMP_SET || mode == M_CMP_CLR) ? cmp_pin : 1'b0;
      default: pin_o = 1'b0;
    endcase
  end

  assign irq_o     = cap_irq | cmp_irq;
  assign tmr_clr_o = go;
  assign adc_go_o  = go;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kind == K_OFF && $past(kind) == K_OFF) |-> !irq_o); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (!irq_o && !adc_go_o && cap_val_o == '0)); // R1
endmodule

// File: tb/sim_ccp_unit.sv
module sim_ccp_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  ctrl_i;
  logic [15:0] timer_i, cmp_val_i;
  logic        cap_pin_i;
  logic [7:0]  duty_hi_i;
  logic [9:0]  pwm_cnt_i;
  logic        pwm_start_i;
  logic [15:0] cap_val_o;
  logic        pin_o, irq_o, tmr_clr_o, adc_go_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ccp_unit u0 (.*);

  // PWM vectors: {mode, duty[9:0], expected high cycles per 20-cycle period}
  localparam logic [24:0] PWM_TAB [8] = '{
    {4'b1100, 10'd0,   11'd0},  {4'b1111, 10'd1,   11'd1},
    {4'b1101, 10'd5,   11'd5},  {4'b1110, 10'd6,   11'd6},
    {4'b1100, 10'd19,  11'd19}, {4'b1111, 10'd20,  11'd20},
    {4'b1100, 10'd700, 11'd20}, {4'b1110, 10'd3,   11'd3}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_mode(input logic [3:0] m);
    ctrl_i[3:0] = m;
    tick();
  endtask

  // one rising pin edge with timer value v; returns irq seen after it
  task automatic rise_pulse(input logic [15:0] v, output logic got);
    cap_pin_i = 1'b0; timer_i = 16'h0; tick();
    cap_pin_i = 1'b1; timer_i = v; tick();
    got = irq_o;
  endtask

  task automatic pwm_period(input int chg_k, input logic [9:0] new_duty, output int hi);
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      if (k == chg_k) begin
        duty_hi_i = new_duty[9:2]; ctrl_i[5:4] = new_duty[1:0];
      end
      pwm_cnt_i = 10'(k); pwm_start_i = (k == 0);
      tick();
      hi += int'(pin_o);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic got;
    int   hi, nirq;
    logic [15:0] held;
    rst_n = 1'b0; ctrl_i = '0; timer_i = '0; cmp_val_i = 16'h0050;
    cap_pin_i = 1'b0; duty_hi_i = '0; pwm_cnt_i = '0; pwm_start_i = 1'b0;
    #20;
    // R1 during reset
    chk("R1 pin", pin_o, 0); chk("R1 irq", irq_o, 0);
    chk("R1 cap", cap_val_o, 0); chk("R1 go", {tmr_clr_o, adc_go_o}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 after release", {pin_o, irq_o, tmr_clr_o, adc_go_o}, 0);

    // R10 / R11: table-driven PWM
    for (int i = 0; i < 8; i++) begin
      ctrl_i = {PWM_TAB[i][12:11], PWM_TAB[i][24:21]};
      duty_hi_i = PWM_TAB[i][20:13];
      pwm_period(99, 10'd0, hi);
      pwm_period(99, 10'd0, hi);
      chk($sformatf("R10 duty %0d", PWM_TAB[i][20:11]), hi, 32'(PWM_TAB[i][10:0]));
    end
    // R11: mid-period change waits for next period
    ctrl_i = {2'b01, 4'b1100}; duty_hi_i = 8'd1;   // duty 5
    pwm_period(99, 10'd0, hi);
    pwm_period(3, 10'd15, hi);
    chk("R11 old duty kept", hi, 5);
    pwm_period(99, 10'd0, hi);
    chk("R11 new duty used", hi, 15);
    pwm_cnt_i = '0; pwm_start_i = 1'b0; ctrl_i[5:4] = 2'b00;

    // R3: falling-edge capture
    set_mode(4'b0100);
    cap_pin_i = 1'b1; timer_i = 16'h1111; tick();
    chk("R3 rise ignored", {irq_o, cap_val_o}, 0);
    cap_pin_i = 1'b0; timer_i = 16'h1234; tick();
    chk("R3 fall captured", cap_val_o, 16'h1234); chk("R3 irq", irq_o, 1);
    tick();
    chk("R3 irq one cycle", irq_o, 0);

    // R4: rising-edge capture
    set_mode(4'b0101);
    rise_pulse(16'hBEEF, got);
    chk("R4 rise irq", got, 1); chk("R4 rise captured", cap_val_o, 16'hBEEF);
    cap_pin_i = 1'b0; timer_i = 16'h7777; tick();
    chk("R4 fall ignored", {irq_o, cap_val_o}, {1'b0, 16'hBEEF});

    // R5: every 4th rising edge
    set_mode(4'b0110);
    nirq = 0;
    for (int i = 1; i <= 3; i++) begin rise_pulse(16'(100 + i), got); nirq += int'(got); end
    chk("R5 no irq before 4th", nirq, 0);
    rise_pulse(16'd104, got);
    chk("R5 4th edge irq", got, 1); chk("R5 4th edge value", cap_val_o, 16'd104);
    // R5: every 16th rising edge
    cap_pin_i = 1'b0; set_mode(4'b0111);
    nirq = 0;
    for (int i = 1; i <= 15; i++) begin rise_pulse(16'(200 + i), got); nirq += int'(got); end
    chk("R5 no irq before 16th", nirq, 0);
    rise_pulse(16'd216, got);
    chk("R5 16th edge", {got, cap_val_o}, {1'b1, 16'd216});

    // R6: mode change clears the count
    cap_pin_i = 1'b0; set_mode(4'b0110);
    rise_pulse(16'd1, got); rise_pulse(16'd2, got);
    cap_pin_i = 1'b0; set_mode(4'b0101); set_mode(4'b0110);
    nirq = 0;
    for (int i = 0; i < 3; i++) begin rise_pulse(16'(300 + i), got); nirq += int'(got); end
    chk("R6 count restarted", nirq, 0);
    rise_pulse(16'd303, got);
    chk("R6 capture on 4th after change", {got, cap_val_o}, {1'b1, 16'd303});
    cap_pin_i = 1'b0;

    // R7 / R8: compare clear and set
    timer_i = 16'h0; set_mode(4'b1001);
    chk("R7 entry preset high", pin_o, 1);
    timer_i = 16'h0050; tick();
    chk("R7 clear on match", {pin_o, irq_o}, 2'b01);
    tick();
    chk("R8 held equality no second irq", irq_o, 0);
    timer_i = 16'h0; set_mode(4'b1000);
    chk("R7 entry preset low", pin_o, 0);
    timer_i = 16'h0050; tick();
    chk("R7 set on match", {pin_o, irq_o}, 2'b11);
    timer_i = 16'h0; set_mode(4'b1010);
    timer_i = 16'h0050; tick();
    chk("R8 irq-only match", {pin_o, irq_o, adc_go_o}, 3'b010);

    // R9: special event
    timer_i = 16'h0; set_mode(4'b1011);
    timer_i = 16'h0050; tick();
    chk("R9 trigger pulse", {tmr_clr_o, adc_go_o, irq_o, pin_o}, 4'b1110);
    tick();
    chk("R9 trigger one cycle", {tmr_clr_o, adc_go_o}, 2'b00);

    // R2: off codes
    held = cap_val_o;
    timer_i = 16'h0; set_mode(4'b0000);
    nirq = 0;
    for (int i = 0; i < 3; i++) begin
      rise_pulse(16'h0050, got); nirq += int'(got);
      cap_pin_i = 1'b0; tick(); nirq += int'(irq_o);
    end
    chk("R2 off no irq", nirq, 0);
    chk("R2 off holds capture", cap_val_o, held);
    ctrl_i[5:4] = 2'b11; duty_hi_i = 8'hFF; set_mode(4'b0010);
    pwm_period(99, 10'h3FF, hi);
    chk("R2 unlisted code pin low", hi, 0);

    done = 1'b1;
    finish_run();
  end
endmodule